// File: doc/BRIEF.md
# Exception Entry State Unit

This unit computes, in one registered step, the processor state to be committed when an exception is taken. A request presents a cause code together with the current machine state word, the address of the affected instruction, a cause-specific error code, two partition-control bits, a system-call level and a table of handler vectors indexed by cause. One clock later the unit presents the following values and raises a one-cycle commit strobe:

- the status word to save;
- the return address to save;
- a select between the normal save-register pair and the hypervisor save-register pair;
- the machine state word the handler starts with;
- the handler entry address.

A cause whose vector is not implemented, and a cause code outside the defined set, raise a one-cycle fault strobe in place of the commit strobe. Deciding which exception to take, fetching at the vector and any translation maintenance belong to the surrounding pipeline.

Machine state bit positions (bit 0 is the least significant): little-endian LE = 0, recoverable RI = 1, machine-check enable ME = 12, interrupt-little-endian ILE = 16, power-save POW = 18, hypervisor HV = 60, interrupt-64-bit ISF = 61, 64-bit mode SF = 63.

Cause codes:

| Code | Cause |
|------|-------|
| 0 | system reset |
| 1 | machine check |
| 2 | data storage |
| 3 | instruction storage |
| 4 | external input |
| 5 | alignment |
| 6 | program |
| 7 | floating-point unavailable |
| 8 | decrementer |
| 9 | system call |
| 10 | trace |
| 11 | data segment |
| 12 | instruction segment |
| 13 | vector unavailable |
| 14 | hypervisor decrementer |
| 15 | hypervisor data storage |
| 16 | hypervisor instruction storage |
| 17 | hypervisor data segment |
| 18 | hypervisor instruction segment |

Top module: `exc_entry_unit`

## Requirements
- R1: While rst_n is low, and until the first request after it, commit_o and fault_o are 0 and every data output is zero.
- R2: A request sampled on req_i at a rising edge drives exactly one of commit_o or fault_o high for the following cycle only. The data outputs change only on a commit, and otherwise hold their last values.
- R3: The saved status is msr_i with bits 16–21 and 27–30 cleared (mask 0x783F0000). Cause-specific bits are ORed in after the clearing. The instruction-storage cause (3) ORs the whole err_code_i into it.
- R4: For the program cause (6), err_code_i[1:0] selects a value ORed into the saved status: 0 gives 0x00100000 (floating-point enabled), 1 gives 0x00080000 (illegal instruction), 2 gives 0x00040000 (privileged), 3 gives 0x00020000 (trap).
- R5: The new machine state starts at zero with only ME copied from msr_i. RI is 0 for every cause outside the hypervisor class. The machine-check cause (1) always clears ME.
- R6: For system reset (0), when msr_i[POW] is 1 the value 0x10000 is ORed into the saved status and ME is kept. When it is 0, ME is cleared.
- R7: Causes 14 to 18 select the hypervisor save pair (use_hv_pair_o = 1), set HV, and copy RI from msr_i. All other causes select the normal pair.
- R8: Causes 2, 3, 5, 6, 7, 8, 10, 11, 12 and 13 set HV only when lpes1_i is 0. External input (4) sets HV only when lpes0_i is 1. Reset and machine check never set HV.
- R9: The system call (9) sets HV when sc_lev_i equals 1, or when lpes0_i and lpes1_i are both 0.
- R10: The new machine state has LE set exactly when msr_i[ILE] is 1.
- R11: When msr_i[ISF] is 1, SF is set in the new machine state and the vector is the full table entry. Otherwise SF is 0 and the vector is the entry's low 32 bits, zero-extended.
- R12: The saved return address is pc_i for causes 5, 6, 7 and 13, and pc_i + 4 for every other cause.
- R13: A cause code of 19 or more, or a table entry of all ones, gives fault_o instead of commit_o, and leaves every data output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Take an exception this cycle |
| cause_i | input | 5 | Cause code |
| msr_i | input | 64 | Current machine state word |
| err_code_i | input | 64 | Cause-specific error code |
| pc_i | input | 64 | Address of the affected instruction |
| lpes0_i | input | 1 | Partition control bit 0 |
| lpes1_i | input | 1 | Partition control bit 1 |
| sc_lev_i | input | LEV_W (7) | System-call level field |
| vec_table_i | input | 19*64 | Handler vectors; entry i occupies bits [i*64 +: 64] |
| commit_o | output | 1 | One-cycle strobe: entry state valid |
| fault_o | output | 1 | One-cycle strobe: unimplemented or unknown cause |
| save_status_o | output | 64 | Status word to save |
| save_addr_o | output | 64 | Return address to save |
| use_hv_pair_o | output | 1 | 1 = hypervisor save pair, 0 = normal pair |
| new_msr_o | output | 64 | Machine state for the handler |
| vector_o | output | 64 | Handler entry address |

## Verification
Directed requests cover the following patterns, each chosen to tell one rule apart from its neighbours:

- an all-ones machine state against an all-zero one, which separates the cleared-mask bits from the bits carried through;
- the power-save and machine-check cases, which show whether ME is kept or dropped;
- every hypervisor-class cause with RI both set and clear, which shows that RI is copied only for that class;
- each partition-bit combination against storage, external and system-call causes, which checks every hypervisor-bit rule;
- the ILE and ISF settings, which show the little-endian bit, the 64-bit mode bit and the truncation of the high vector half;
- store-current against store-next causes, which shows the return address;
- an all-ones table entry and out-of-range codes, which must fault and leave the outputs held.

Back-to-back requests and a long run of pseudo-random requests are compared against a behavioural model on every cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN       = 64;
    localparam int CAUSE_W    = 5;
    localparam int NUM_CAUSES = 19;

    // machine state bit positions
    localparam int B_LE  = 0;
    localparam int B_RI  = 1;
    localparam int B_ME  = 12;
    localparam int B_ILE = 16;
    localparam int B_POW = 18;
    localparam int B_HV  = 60;
    localparam int B_ISF = 61;
    localparam int B_SF  = 63;

    localparam logic [XLEN-1:0] STATUS_CLEAR = 64'h0000_0000_783F_0000;
    localparam logic [XLEN-1:0] WAKE_FLAG    = 64'h0000_0000_0001_0000;
    localparam logic [XLEN-1:0] PRG_FPE      = 64'h0000_0000_0010_0000;
    localparam logic [XLEN-1:0] PRG_ILL      = 64'h0000_0000_0008_0000;
    localparam logic [XLEN-1:0] PRG_PRIV     = 64'h0000_0000_0004_0000;
    localparam logic [XLEN-1:0] PRG_TRAP     = 64'h0000_0000_0002_0000;

    typedef enum logic [CAUSE_W-1:0] {
        C_RESET       = 5'd0,
        C_MCHECK      = 5'd1,
        C_DSTORE      = 5'd2,
        C_ISTORE      = 5'd3,
        C_EXTIN       = 5'd4,
        C_ALIGN       = 5'd5,
        C_PROGRAM     = 5'd6,
        C_FP_UNAVAIL  = 5'd7,
        C_DECR        = 5'd8,
        C_SYSCALL     = 5'd9,
        C_TRACE       = 5'd10,
        C_DSEG        = 5'd11,
        C_ISEG        = 5'd12,
        C_VEC_UNAVAIL = 5'd13,
        C_HDECR       = 5'd14,
        C_HDSTORE     = 5'd15,
        C_HISTORE     = 5'd16,
        C_HDSEG       = 5'd17,
        C_HISEG       = 5'd18
    } cause_e;

    typedef enum logic [2:0] {
        HV_NEVER,
        HV_IF_LPES1_CLR,
        HV_IF_LPES0_SET,
        HV_SYSCALL_RULE,
        HV_ALWAYS
    } hv_rule_e;

    typedef struct packed {
        logic     known;
        logic     ret_next;
        logic     hv_pair;
        hv_rule_e hv_rule;
    } cause_attr_t;

    function automatic cause_attr_t cause_attr(input logic [CAUSE_W-1:0] code);
        cause_attr_t a;
        a.known    = 1'b1;
        a.ret_next = 1'b1;
        a.hv_pair  = 1'b0;
        a.hv_rule  = HV_IF_LPES1_CLR;
        case (code)
            C_RESET, C_MCHECK:       a.hv_rule = HV_NEVER;
            C_EXTIN:                 a.hv_rule = HV_IF_LPES0_SET;
            C_SYSCALL:               a.hv_rule = HV_SYSCALL_RULE;
            C_ALIGN, C_PROGRAM,
            C_FP_UNAVAIL,
            C_VEC_UNAVAIL:           a.ret_next = 1'b0;
            C_DSTORE, C_ISTORE, C_DECR, C_TRACE,
            C_DSEG, C_ISEG:          a.hv_rule = HV_IF_LPES1_CLR;
            C_HDECR, C_HDSTORE, C_HISTORE,
            C_HDSEG, C_HISEG: begin
                a.hv_pair = 1'b1;
                a.hv_rule = HV_ALWAYS;
            end
            default: begin
                a.known   = 1'b0;
                a.hv_rule = HV_NEVER;
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/exc_status_calc.sv
module exc_status_calc
    import exc_entry_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  cause_attr_t        attr_i,
    input  logic [XLEN-1:0]    msr_i,
    input  logic [XLEN-1:0]    err_code_i,
    input  logic [XLEN-1:0]    pc_i,
    output logic [XLEN-1:0]    status_o,
    output logic [XLEN-1:0]    ret_addr_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] extra;

    assign base = msr_i & ~STATUS_CLEAR;

    always_comb begin
        extra = '0;
        case (cause_i)
            C_RESET:   extra = msr_i[B_POW] ? WAKE_FLAG : '0;
            C_ISTORE:  extra = err_code_i;
            C_PROGRAM: begin
                case (err_code_i[1:0])
                    2'd0:    extra = PRG_FPE;
                    2'd1:    extra = PRG_ILL;
                    2'd2:    extra = PRG_PRIV;
                    default: extra = PRG_TRAP;
                endcase
            end
            default:   extra = '0;
        endcase
    end

    assign status_o   = base | extra;
    assign ret_addr_o = attr_i.ret_next ? pc_i + STEP : pc_i;

endmodule

// File: rtl/exc_msr_calc.sv
module exc_msr_calc
    import exc_entry_pkg::*;
#(
    parameter int LEV_W = 7
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  cause_attr_t        attr_i,
    input  logic [XLEN-1:0]    msr_i,
    input  logic               lpes0_i,
    input  logic               lpes1_i,
    input  logic [LEV_W-1:0]   sc_lev_i,
    output logic [XLEN-1:0]    new_msr_o,
    output logic               hv_pair_o
);
    logic hv_set;
    logic keep_me;

    always_comb begin
        case (attr_i.hv_rule)
            HV_ALWAYS:       hv_set = 1'b1;
            HV_IF_LPES1_CLR: hv_set = ~lpes1_i;
            HV_IF_LPES0_SET: hv_set = lpes0_i;
            HV_SYSCALL_RULE: hv_set = (sc_lev_i == LEV_W'(1)) || (!lpes0_i && !lpes1_i);
            default:         hv_set = 1'b0;
        endcase
    end

    always_comb begin
        keep_me = msr_i[B_ME];
        if (cause_i == C_MCHECK) begin
            keep_me = 1'b0;
        end else if (cause_i == C_RESET && !msr_i[B_POW]) begin
            keep_me = 1'b0;
        end
    end

    always_comb begin
        new_msr_o        = '0;
        new_msr_o[B_ME]  = keep_me;
        new_msr_o[B_HV]  = hv_set;
        new_msr_o[B_RI]  = attr_i.hv_pair & msr_i[B_RI];
        new_msr_o[B_LE]  = msr_i[B_ILE];
        new_msr_o[B_SF]  = msr_i[B_ISF];
    end

    assign hv_pair_o = attr_i.hv_pair;

endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter int N = NUM_CAUSES
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               known_i,
    input  logic               wide_i,
    input  logic [N*XLEN-1:0]  table_i,
    output logic [XLEN-1:0]    vector_o,
    output logic               fault_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] entry [N];
    logic [XLEN-1:0] picked;
    logic            in_range;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign entry[g] = table_i[g*XLEN +: XLEN];
    end

    assign in_range = (32'(cause_i) < N) && known_i;

    always_comb begin
        picked = '1;
        for (int i = 0; i < N; i++) begin
            if (32'(cause_i) == i) begin
                picked = entry[i];
            end
        end
    end

    assign fault_o  = !in_range || (picked == '1);
    assign vector_o = wide_i ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int LEV_W      = 7,
    parameter int INSN_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic [CAUSE_W-1:0]         cause_i,
    input  logic [XLEN-1:0]            msr_i,
    input  logic [XLEN-1:0]            err_code_i,
    input  logic [XLEN-1:0]            pc_i,
    input  logic                       lpes0_i,
    input  logic                       lpes1_i,
    input  logic [LEV_W-1:0]           sc_lev_i,
    input  logic [NUM_CAUSES*XLEN-1:0] vec_table_i,
    output logic                       commit_o,
    output logic                       fault_o,
    output logic [XLEN-1:0]            save_status_o,
    output logic [XLEN-1:0]            save_addr_o,
    output logic                       use_hv_pair_o,
    output logic [XLEN-1:0]            new_msr_o,
    output logic [XLEN-1:0]            vector_o
);
    typedef struct packed {
        logic            commit;
        logic            fault;
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] ret_addr;
        logic            hv_pair;
        logic [XLEN-1:0] new_msr;
        logic [XLEN-1:0] vector;
    } entry_state_t;

    cause_attr_t     attr;
    logic [XLEN-1:0] status_c;
    logic [XLEN-1:0] ret_c;
    logic [XLEN-1:0] msr_c;
    logic            hv_pair_c;
    logic [XLEN-1:0] vector_c;
    logic            fault_c;

    entry_state_t state_d;
    entry_state_t state_q;

    assign attr = cause_attr(cause_i);

    exc_status_calc #(.INSN_BYTES(INSN_BYTES)) u_status (
        .cause_i    (cause_i),
        .attr_i     (attr),
        .msr_i      (msr_i),
        .err_code_i (err_code_i),
        .pc_i       (pc_i),
        .status_o   (status_c),
        .ret_addr_o (ret_c)
    );

    exc_msr_calc #(.LEV_W(LEV_W)) u_msr (
        .cause_i   (cause_i),
        .attr_i    (attr),
        .msr_i     (msr_i),
        .lpes0_i   (lpes0_i),
        .lpes1_i   (lpes1_i),
        .sc_lev_i  (sc_lev_i),
        .new_msr_o (msr_c),
        .hv_pair_o (hv_pair_c)
    );

    exc_vec_sel #(.N(NUM_CAUSES)) u_vec (
        .cause_i  (cause_i),
        .known_i  (attr.known),
        .wide_i   (msr_i[B_ISF]),
        .table_i  (vec_table_i),
        .vector_o (vector_c),
        .fault_o  (fault_c)
    );

    always_comb begin
        state_d        = state_q;
        state_d.commit = 1'b0;
        state_d.fault  = 1'b0;
        if (req_i) begin
            if (fault_c) begin
                state_d.fault = 1'b1;
            end else begin
                state_d.commit   = 1'b1;
                state_d.status   = status_c;
                state_d.ret_addr = ret_c;
                state_d.hv_pair  = hv_pair_c;
                state_d.new_msr  = msr_c;
                state_d.vector   = vector_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign commit_o      = state_q.commit;
    assign fault_o       = state_q.fault;
    assign save_status_o = state_q.status;
    assign save_addr_o   = state_q.ret_addr;
    assign use_hv_pair_o = state_q.hv_pair;
    assign new_msr_o     = state_q.new_msr;
    assign vector_o      = state_q.vector;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int LEV_W      = 7,
    parameter int INSN_BYTES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_i,
    input logic [CAUSE_W-1:0]         cause_i,
    input logic [XLEN-1:0]            msr_i,
    input logic [XLEN-1:0]            err_code_i,
    input logic [XLEN-1:0]            pc_i,
    input logic                       lpes0_i,
    input logic                       lpes1_i,
    input logic [LEV_W-1:0]           sc_lev_i,
    input logic [NUM_CAUSES*XLEN-1:0] vec_table_i,
    input logic                       commit_o,
    input logic                       fault_o,
    input logic [XLEN-1:0]            save_status_o,
    input logic [XLEN-1:0]            save_addr_o,
    input logic                       use_hv_pair_o,
    input logic [XLEN-1:0]            new_msr_o,
    input logic [XLEN-1:0]            vector_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && fault_o));

    p_commit_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(req_i));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> ($stable(new_msr_o) && $stable(save_status_o) &&
                       $stable(save_addr_o) && $stable(vector_o)));

    p_ri_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !use_hv_pair_o) |-> !new_msr_o[B_RI]);

    p_mchk_me_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && $past(cause_i) == C_MCHECK) |-> !new_msr_o[B_ME]);

    p_hv_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && use_hv_pair_o) |-> new_msr_o[B_HV]);

    p_le_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (new_msr_o[B_LE] == $past(msr_i[B_ILE])));

    p_trunc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !new_msr_o[B_SF]) |-> (vector_o[XLEN-1:XLEN/2] == '0));

    p_ret_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (save_addr_o == $past(pc_i) || save_addr_o == $past(pc_i) + STEP));

    p_fault_after_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(req_i));

endmodule

bind exc_entry_unit exc_entry_chk #(.LEV_W(LEV_W), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 19;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [4:0]    cause_i = '0;
    logic [63:0]   msr_i = '0;
    logic [63:0]   err_code_i = '0;
    logic [63:0]   pc_i = '0;
    logic          lpes0_i = 1'b0;
    logic          lpes1_i = 1'b0;
    logic [LW-1:0] sc_lev_i = '0;
    logic [NC*64-1:0] vec_table_i;
    logic          commit_o, fault_o, use_hv_pair_o;
    logic [63:0]   save_status_o, save_addr_o, new_msr_o, vector_o;

    logic [63:0] vtab [NC];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // expected outputs
    bit          e_commit, e_fault, e_hvp;
    logic [63:0] e_st, e_ra, e_nm, e_vo;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) vec_table_i[i*64 +: 64] = vtab[i];
    end

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cause_i(cause_i),
        .msr_i(msr_i), .err_code_i(err_code_i), .pc_i(pc_i),
        .lpes0_i(lpes0_i), .lpes1_i(lpes1_i), .sc_lev_i(sc_lev_i),
        .vec_table_i(vec_table_i), .commit_o(commit_o), .fault_o(fault_o),
        .save_status_o(save_status_o), .save_addr_o(save_addr_o),
        .use_hv_pair_o(use_hv_pair_o), .new_msr_o(new_msr_o), .vector_o(vector_o)
    );

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string st_tag;
        st_tag = e_commit ? e_tag : (e_fault ? "R13" : "R2");
        cmp(e_commit ? "R2" : st_tag, "commit", 64'(commit_o), 64'(e_commit));
        cmp(e_fault ? "R13" : st_tag, "fault", 64'(fault_o), 64'(e_fault));
        cmp(st_tag, "status(R3)", save_status_o, e_st);
        cmp(st_tag, "ret addr(R12)", save_addr_o, e_ra);
        cmp(st_tag, "hv pair(R7)", 64'(use_hv_pair_o), 64'(e_hvp));
        cmp(st_tag, "new msr(R5)", new_msr_o, e_nm);
        cmp(st_tag, "vector(R11)", vector_o, e_vo);
    endtask

    // behavioural model of one exception entry
    function automatic bit model(input int c, input logic [63:0] m, input logic [63:0] err,
                                 input logic [63:0] pc, input bit l0, input bit l1,
                                 input int lev, output logic [63:0] st, output logic [63:0] ra,
                                 output logic [63:0] nm, output logic [63:0] vo, output bit hvp);
        bit hv_class, at_current;
        logic [63:0] ent;
        hv_class   = (c >= 14 && c <= 18);
        at_current = (c == 5 || c == 6 || c == 7 || c == 13);
        ent = (c < NC) ? vtab[c] : '1;
        st = m & ~64'h783F0000;
        nm = '0;
        nm[12] = m[12];
        ra = at_current ? pc : pc + 64'd4;
        hvp = hv_class;
        if (c == 0) begin
            if (m[18]) st = st | 64'h10000;
            else       nm[12] = 1'b0;
        end
        if (c == 1) nm[12] = 1'b0;
        if (c == 3) st = st | err;
        if (c == 6) begin
            if (err[1:0] == 2'd0)      st = st | 64'h0010_0000;
            else if (err[1:0] == 2'd1) st = st | 64'h0008_0000;
            else if (err[1:0] == 2'd2) st = st | 64'h0004_0000;
            else                       st = st | 64'h0002_0000;
        end
        if (hv_class) begin
            nm[60] = 1'b1;
            nm[1]  = m[1];
        end else if (c == 4) begin
            nm[60] = l0;
        end else if (c == 9) begin
            nm[60] = (lev == 1) || (!l0 && !l1);
        end else if (c >= 2 && c <= 13) begin
            nm[60] = !l1;
        end
        if (m[16]) nm[0] = 1'b1;
        if (m[61]) begin
            nm[63] = 1'b1;
            vo = ent;
        end else begin
            vo = {32'h0, ent[31:0]};
        end
        return (c < NC) && (ent != '1);
    endfunction

    // one cycle: check the outputs of the last edge, then drive and predict
    task automatic cycle(input bit r, input int c, input logic [63:0] m, input logic [63:0] err,
                         input logic [63:0] pc, input bit l0, input bit l1, input int lev,
                         input string tag);
        logic [63:0] st, ra, nm, vo;
        bit hvp, ok;
        @(negedge clk);
        compare_all();
        req_i = r; cause_i = 5'(c); msr_i = m; err_code_i = err; pc_i = pc;
        lpes0_i = l0; lpes1_i = l1; sc_lev_i = LW'(lev);
        e_commit = 0; e_fault = 0;
        if (r) begin
            ok = model(c, m, err, pc, l0, l1, lev, st, ra, nm, vo, hvp);
            if (ok) begin
                e_commit = 1; e_st = st; e_ra = ra; e_nm = nm; e_vo = vo; e_hvp = hvp;
                e_tag = tag;
            end else begin
                e_fault = 1;
            end
        end
    endtask

    task automatic req(input int c, input logic [63:0] m, input logic [63:0] err,
                       input logic [63:0] pc, input bit l0, input bit l1, input int lev,
                       input string tag);
        cycle(1, c, m, err, pc, l0, l1, lev, tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) vtab[i] = 64'h0000_0040_8000_0000 + 64'(i) * 64'h100;
        e_commit = 0; e_fault = 0; e_hvp = 0;
        e_st = '0; e_ra = '0; e_nm = '0; e_vo = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen by the first comparisons
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R3: mask clearing, all ones and instruction-storage error code
        req(2, '1, 0, 64'h1000, 1, 1, 0, "R3");
        req(3, 64'h0, 64'h4000_0000, 64'h1100, 1, 1, 0, "R3");
        // R4: program subtypes
        for (int k = 0; k < 4; k++) req(6, 64'h1000, 64'(k), 64'h2000, 1, 1, 0, "R4");
        // R5: ME kept, RI dropped; machine check drops ME
        req(4, 64'h1002, 0, 64'h3000, 0, 0, 0, "R5");
        req(1, 64'h1002, 0, 64'h3004, 0, 0, 0, "R5");
        // R6: reset with and without power save
        req(0, 64'h4_1000, 0, 64'h100, 0, 0, 0, "R6");
        req(0, 64'h0_1000, 0, 64'h100, 0, 0, 0, "R6");
        // R7: hypervisor-class causes, RI set and clear
        for (int k = 14; k <= 18; k++) begin
            req(k, 64'h1002, 0, 64'h4000, 1, 1, 0, "R7");
            req(k, 64'h1000, 0, 64'h4000, 1, 1, 0, "R7");
        end
        // R8: partition bits
        req(2, 0, 0, 64'h500, 0, 0, 0, "R8");
        req(2, 0, 0, 64'h500, 0, 1, 0, "R8");
        req(4, 0, 0, 64'h500, 1, 1, 0, "R8");
        req(4, 0, 0, 64'h500, 0, 0, 0, "R8");
        req(0, 64'h4_0000, 0, 64'h500, 0, 0, 0, "R8");
        // R9: system call level and partition bits
        req(9, 0, 0, 64'h600, 1, 1, 1, "R9");
        req(9, 0, 0, 64'h600, 0, 0, 0, "R9");
        req(9, 0, 0, 64'h600, 0, 1, 2, "R9");
        // R10: interrupt little-endian
        req(8, 64'h1_0000, 0, 64'h700, 1, 1, 0, "R10");
        req(8, 64'h0, 0, 64'h700, 1, 1, 0, "R10");
        // R11: wide vector and truncation
        req(10, 64'h2000_0000_0000_0000, 0, 64'h800, 1, 1, 0, "R11");
        req(10, 64'h0, 0, 64'h800, 1, 1, 0, "R11");
        // R12: store-current against store-next
        req(5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFC, 1, 1, 0, "R12");
        req(13, 0, 0, 64'h900, 1, 1, 0, "R12");
        req(11, 0, 0, 64'h900, 1, 1, 0, "R12");
        // R13: unimplemented vector and unknown codes, outputs held
        vtab[12] = '1;
        req(12, '1, '1, 64'hA00, 0, 0, 0, "R13");
        req(25, '1, '1, 64'hA00, 0, 0, 0, "R13");
        req(19, '1, '1, 64'hA00, 0, 0, 0, "R13");
        vtab[12] = 64'h0000_0040_8000_0C00;
        // R2: back-to-back requests
        cycle(1, 7, 64'h1000, 0, 64'hB00, 0, 1, 0, "R2");
        cycle(1, 16, 64'h2000_0000_0001_1002, 0, 64'hB04, 0, 1, 0, "R2");
        cycle(1, 30, 0, 0, 64'hB08, 0, 1, 0, "R2");
        cycle(1, 9, 0, 0, 64'hB0C, 1, 0, 1, "R2");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // mixed pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            int c;
            c = int'($urandom_range(0, 20));
            cycle(($urandom_range(0, 3) != 0), c,
                  {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  int'($urandom_range(0, 3)), "R2");
        end
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        @(negedge clk);
        compare_all();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule